// File: doc/BRIEF.md
# DDR3 Burst Column Sequencer

This block turns one read or write command into the ordered list of column addresses that a DDR3-style burst touches. Its burst settings come from the low byte of a mode register: a two-bit length code, a one-bit order select and two bits that must stay zero. Each command brings a one-cycle start strobe, a write flag, a starting column and a per-command chop select, which stands for address bit 12. The block then emits one column per cycle with a valid flag, and a last flag on the final beat. A burst is four beats (chop) or eight beats.

The beat order depends on the order select, the burst size and the low three bits of the starting column. Sequential order wraps inside the aligned group: within a nibble the two low bits count upward modulo four, and the second half of an eight-beat burst uses the other nibble. Interleaved order XORs the beat index into the low bits. Reads may start on any column. Writes have their start pulled down to the nibble boundary (chop) or the eight-column boundary (full burst).

Top module: `ddr_burst_colgen`

## Requirements
- R1: The length code `cfg_burst_len` decodes as 00 = always 8 beats, 10 = always 4 beats, 01 = chosen per command: `cmd_len8` high gives 8 beats and low gives 4 beats. Outside code 01, `cmd_len8` has no effect.
- R2: `cfg_err` is high exactly when `cfg_rsvd[0]` (register bit 2) is set, `cfg_rsvd[1]` (register bit 7) is set, or the length code is 11. A start presented while `cfg_err` is high produces no beats.
- R3: An accepted start shows beat 0 on the cycle after the start edge, the remaining beats follow on consecutive cycles, and `beat_valid` is low whenever no burst is in progress, including after reset.
- R4: A burst holds `beat_valid` for exactly 4 cycles (chop) or 8 cycles, and `beat_last` is high only on its final beat.
- R5: With `cfg_interleave` = 0 and 8 beats, beat i has column[2] = start[2] XOR (i >= 4) and column[1:0] = (start[1:0] + i) mod 4.
- R6: With `cfg_interleave` = 1, beat i has column[2:0] = start[2:0] XOR i.
- R7: A 4-beat chop keeps column[2] of the start. Its column[1:0] is (start[1:0] + i) mod 4 when sequential, and start[1:0] XOR i when interleaved.
- R8: Column bits above bit 2 equal those of the starting column on every beat.
- R9: For a write (`cmd_write` = 1), the start's column[2:0] is taken as 0 in an 8-beat burst, and its column[1:0] as 0 in a chop burst. Reads use the start as given.
- R10: A start that arrives while a burst has beats still to show (the beat on the output is not the last one) is ignored. A start that arrives on the cycle where the last beat is shown is accepted, and its beat 0 follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_burst_len | input | 2 | Burst length code (mode register bits 1:0) |
| cfg_interleave | input | 1 | Order select: 0 sequential, 1 interleaved (mode register bit 3) |
| cfg_rsvd | input | 2 | Reserved mode bits: [0] is register bit 2, [1] is register bit 7 |
| cmd_start | input | 1 | One-cycle command strobe |
| cmd_write | input | 1 | 1 for a write burst, 0 for a read burst |
| cmd_col | input | COL_W | Starting column address |
| cmd_len8 | input | 1 | Per-command size select (address bit 12) for length code 01 |
| cfg_err | output | 1 | Illegal mode setting |
| beat_valid | output | 1 | A column is presented this cycle |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Final beat of the burst |

## Verification
The bench runs every length code with both values of the size select, both order types, both directions and all eight low start offsets, and random upper column bits. Each output is compared on every clock with a behavioural queue model. Reads at all eight offsets separate the sequential wrap from the interleaved XOR. Chop bursts show whether column[2] is held. Writes at non-zero offsets show whether the boundary forcing is missing or applied with the wrong width. Separate runs apply each illegal setting, hold start high through a burst to show that it is ignored, and then raise start on the last beat to show that the next burst follows with no gap.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;

    localparam int IDX_W = 3;
    localparam logic [IDX_W-1:0] LAST_IDX_CHOP = 3'd3;
    localparam logic [IDX_W-1:0] LAST_IDX_FULL = 3'd7;

    typedef enum logic [1:0] {
        BLEN_FIXED8 = 2'b00,
        BLEN_ON_FLY = 2'b01,
        BLEN_FIXED4 = 2'b10,
        BLEN_ILLEGAL = 2'b11
    } blen_code_e;

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import ddr_burst_pkg::*;
(
    input  logic [1:0] burst_len,
    input  logic       rsvd_lo,
    input  logic       rsvd_hi,
    input  logic       len8_sel,
    output logic       chop_now,
    output logic       bad_cfg
);
    blen_code_e code;

    always_comb begin
        code     = blen_code_e'(burst_len);
        bad_cfg  = rsvd_lo | rsvd_hi;
        chop_now = 1'b0;
        unique case (code)
            BLEN_FIXED8:  chop_now = 1'b0;
            BLEN_ON_FLY:  chop_now = ~len8_sel;
            BLEN_FIXED4:  chop_now = 1'b1;
            BLEN_ILLEGAL: bad_cfg  = 1'b1;
            default:      bad_cfg  = 1'b1;
        endcase
    end
endmodule

// File: rtl/burst_start_align.sv
module burst_start_align #(
    parameter int COL_W = 10
) (
    input  logic             is_write,
    input  logic             is_chop,
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);
    always_comb begin
        col_out = col_in;
        if (is_write) begin
            col_out[1:0] = 2'b00;
            if (!is_chop) begin
                col_out[2] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/burst_order_calc.sv
module burst_order_calc
    import ddr_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [IDX_W-1:0] beat_idx,
    input  logic             interleave,
    output logic [COL_W-1:0] beat_col
);
    logic [1:0] seq_lo;
    logic [2:0] low_bits;

    always_comb begin
        seq_lo = base_col[1:0] + beat_idx[1:0];
        if (interleave) begin
            low_bits = base_col[2:0] ^ beat_idx;
        end else begin
            low_bits = {base_col[2] ^ beat_idx[2], seq_lo};
        end
    end

    assign beat_col[2:0] = low_bits;

    generate
        if (COL_W > 3) begin : g_upper
            assign beat_col[COL_W-1:3] = base_col[COL_W-1:3];
        end
    endgenerate
endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
    import ddr_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_burst_len,
    input  logic             cfg_interleave,
    input  logic [1:0]       cfg_rsvd,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_len8,
    output logic             cfg_err,
    output logic             beat_valid,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_last
);
    typedef struct packed {
        logic             valid;
        logic             last;
        logic             chop;
        logic             ilv;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] col;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic             chop_now;
    logic [COL_W-1:0] aligned_col;
    logic             accept;
    logic [COL_W-1:0] calc_base;
    logic [IDX_W-1:0] calc_idx;
    logic             calc_ilv;
    logic             calc_chop;
    logic [COL_W-1:0] calc_col;

    burst_cfg_decode u_dec (
        .burst_len (cfg_burst_len),
        .rsvd_lo   (cfg_rsvd[0]),
        .rsvd_hi   (cfg_rsvd[1]),
        .len8_sel  (cmd_len8),
        .chop_now  (chop_now),
        .bad_cfg   (cfg_err)
    );

    burst_start_align #(.COL_W(COL_W)) u_align (
        .is_write (cmd_write),
        .is_chop  (chop_now),
        .col_in   (cmd_col),
        .col_out  (aligned_col)
    );

    burst_order_calc #(.COL_W(COL_W)) u_order (
        .base_col   (calc_base),
        .beat_idx   (calc_idx),
        .interleave (calc_ilv),
        .beat_col   (calc_col)
    );

    assign accept = cmd_start && !cfg_err && (!st_q.valid || st_q.last);

    always_comb begin
        calc_base = accept ? aligned_col    : st_q.base;
        calc_idx  = accept ? '0             : st_q.idx + 1'b1;
        calc_ilv  = accept ? cfg_interleave : st_q.ilv;
        calc_chop = accept ? chop_now       : st_q.chop;
    end

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.chop  = chop_now;
            st_d.ilv   = cfg_interleave;
            st_d.wr    = cmd_write;
            st_d.base  = aligned_col;
            st_d.idx   = calc_idx;
            st_d.col   = calc_col;
            st_d.last  = (calc_idx == (calc_chop ? LAST_IDX_CHOP : LAST_IDX_FULL));
        end else if (st_q.valid && !st_q.last) begin
            st_d.idx   = calc_idx;
            st_d.col   = calc_col;
            st_d.last  = (calc_idx == (calc_chop ? LAST_IDX_CHOP : LAST_IDX_FULL));
        end else begin
            st_d.valid = 1'b0;
            st_d.last  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_valid = st_q.valid;
    assign beat_col   = st_q.col;
    assign beat_last  = st_q.last;

    // Independent beat counter, used only by the checks below
    logic [IDX_W-1:0] run_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt_q <= '0;
        end else if (beat_valid) begin
            run_cnt_q <= beat_last ? '0 : run_cnt_q + 1'b1;
        end
    end

    assert_contiguous_beats_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> beat_valid);

    assert_err_blocks_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cfg_err && !beat_valid) |=> !beat_valid);

    assert_last_on_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> (beat_valid && run_cnt_q == (st_q.chop ? LAST_IDX_CHOP : LAST_IDX_FULL)));

    assert_upper_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> (beat_col[COL_W-1:3] == $past(beat_col[COL_W-1:3])));

    assert_write_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && st_q.wr && run_cnt_q == '0) |->
            (beat_col[1:0] == 2'b00 && (st_q.chop || !beat_col[2])));

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> $stable(st_q.base));

endmodule

// File: tb/sim_ddr_burst_colgen.sv
module sim_ddr_burst_colgen;
    localparam int COL_W  = 10;
    localparam int CLK_NS = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cfg_burst_len = 2'b00;
    logic             cfg_interleave = 1'b0;
    logic [1:0]       cfg_rsvd = 2'b00;
    logic             cmd_start = 1'b0;
    logic             cmd_write = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cmd_len8 = 1'b0;
    logic             cfg_err;
    logic             beat_valid;
    logic [COL_W-1:0] beat_col;
    logic             beat_last;

    ddr_burst_colgen #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
        .cfg_rsvd(cfg_rsvd), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .cmd_len8(cmd_len8), .cfg_err(cfg_err),
        .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last)
    );

    always #(CLK_NS/2) clk = ~clk;

    typedef struct { int col; bit last; } beat_t;
    beat_t exp_q[$];
    string col_tag = "R5";
    int    n_chk = 0;
    int    n_fail = 0;
    bit    compare_on = 1'b0;
    bit    model_acc;
    bit    model_chop;
    int    model_n;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit ref_err();
        return cfg_rsvd[0] || cfg_rsvd[1] || (cfg_burst_len == 2'b11);
    endfunction

    function automatic bit ref_chop();
        return (cfg_burst_len == 2'b10) || (cfg_burst_len == 2'b01 && !cmd_len8);
    endfunction

    function automatic int ref_col(input int start, input int i, input bit ilv,
                                   input bit chop, input bit wr);
        int off = start % 8;
        int hi  = start - off;
        if (wr) off = chop ? (off / 4) * 4 : 0;
        if (ilv) return hi + (off ^ i);
        if (i < 4) return hi + (off / 4) * 4 + ((off % 4 + i) % 4);
        return hi + (1 - off / 4) * 4 + ((off % 4 + i) % 4);
    endfunction

    // Behavioural model: queue of beats still to be shown
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
        end else begin
            model_acc  = cmd_start && !ref_err() && (exp_q.size() <= 1);
            model_chop = ref_chop();
            if (exp_q.size() > 0) void'(exp_q.pop_front());
            if (model_acc) begin
                model_n = model_chop ? 4 : 8;
                for (int i = 0; i < model_n; i++) begin
                    beat_t b;
                    b.col  = ref_col(int'(cmd_col), i, cfg_interleave, model_chop, cmd_write);
                    b.last = (i == model_n - 1);
                    exp_q.push_back(b);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (compare_on) begin
            chk(beat_valid == (exp_q.size() > 0), "R3", int'(beat_valid), int'(exp_q.size() > 0));
            chk(cfg_err == ref_err(), "R2", int'(cfg_err), int'(ref_err()));
            if (beat_valid && exp_q.size() > 0) begin
                chk(beat_col[COL_W-1:3] == exp_q[0].col[COL_W-1:3], "R8",
                    int'(beat_col), exp_q[0].col);
                chk(beat_col[2:0] == exp_q[0].col[2:0], col_tag, int'(beat_col), exp_q[0].col);
                chk(beat_last == exp_q[0].last, "R4", int'(beat_last), int'(exp_q[0].last));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic run_burst(input logic [1:0] bl, input bit ilv, input bit wr,
                             input int col, input bit len8, input string tag);
        int cnt = 0;
        int exp_n;
        cfg_burst_len  = bl;
        cfg_interleave = ilv;
        cmd_write      = wr;
        cmd_col        = COL_W'(col);
        cmd_len8       = len8;
        exp_n          = ref_err() ? 0 : (ref_chop() ? 4 : 8);
        cmd_start      = 1'b1;
        tick();
        cmd_start      = 1'b0;
        repeat (10) begin
            if (beat_valid) cnt++;
            tick();
        end
        chk(cnt == exp_n, tag, cnt, exp_n);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int first_col;
        repeat (3) tick();
        chk(beat_valid == 1'b0 && beat_last == 1'b0, "R3", int'(beat_valid), 0);
        rst_n = 1'b1;
        tick();
        compare_on = 1'b1;

        // Every length code, size select, order, direction and low offset
        for (int bl = 0; bl < 3; bl++) begin
            for (int sel = 0; sel < 2; sel++) begin
                for (int ilv = 0; ilv < 2; ilv++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        for (int lo = 0; lo < 8; lo++) begin
                            bit chop_c = (bl == 2) || (bl == 1 && sel == 0);
                            if (wr != 0)        col_tag = "R9";
                            else if (chop_c)    col_tag = "R7";
                            else if (ilv != 0)  col_tag = "R6";
                            else                col_tag = "R5";
                            run_burst(2'(bl), ilv[0], wr[0],
                                      int'($urandom_range(0, (1 << (COL_W - 3)) - 1)) * 8 + lo,
                                      sel[0], (bl == 1) ? "R1" : "R4");
                        end
                    end
                end
            end
        end

        // Illegal settings: no beats
        cfg_rsvd = 2'b01;
        run_burst(2'b00, 1'b0, 1'b0, 'h15, 1'b1, "R2");
        cfg_rsvd = 2'b10;
        run_burst(2'b10, 1'b1, 1'b0, 'h26, 1'b1, "R2");
        cfg_rsvd = 2'b00;
        run_burst(2'b11, 1'b0, 1'b1, 'h37, 1'b1, "R2");

        // Start held high during a burst, then restart on the last beat
        col_tag        = "R10";
        cfg_burst_len  = 2'b00;
        cfg_interleave = 1'b0;
        cmd_write      = 1'b0;
        cmd_len8       = 1'b1;
        cmd_col        = COL_W'('h12B);
        cmd_start      = 1'b1;
        tick();
        cmd_col        = COL_W'('h2C4);
        repeat (5) tick();
        cmd_start      = 1'b0;
        chk(beat_valid && beat_col[COL_W-1:3] == COL_W'('h12B) >> 3, "R10",
            int'(beat_col), 'h12B);
        while (!beat_last) tick();
        cfg_interleave = 1'b1;
        cmd_col        = COL_W'('h35A);
        cmd_start      = 1'b1;
        tick();
        cmd_start      = 1'b0;
        first_col      = ref_col('h35A, 0, 1'b1, 1'b0, 1'b0);
        chk(beat_valid && int'(beat_col) == first_col, "R10", int'(beat_col), first_col);
        repeat (10) tick();
        chk(beat_valid == 1'b0, "R3", int'(beat_valid), 0);

        compare_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule